// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial clock of a two-wire bus master from the peripheral clock. A base tick is produced by two cascaded counters. The first counter divides the peripheral clock by A+1. The second divides that result by B+1. A final phase counter with 22 positions turns the base tick into a square wave, so one serial period lasts 22×(A+1)×(B+1) peripheral cycles. The fastest rate the block can produce is therefore the peripheral clock divided by 22.

Both divisor fields hold the divide value minus one. The block copies them into working registers only while the bus is idle or the block is disabled. A value written during a transfer stays pending at the inputs and takes effect at the next idle point. Alongside the SCL level, the block emits a one-cycle tick at four points of each period: the two SCL edges and the middle of each half. A protocol engine can use these points to place its data and sampling actions.

Top module: `sclk_div_top`

## Requirements
- R1: After reset, scl_o is high and tick_o is low.
- R2: While enabled, the time between consecutive falling edges of scl_o is 22×(A+1)×(B+1) clock cycles, where A is div_a_i and B is div_b_i, each interpreted as an unsigned value.
- R3: Within each period, scl_o is low for exactly 11×(A+1)×(B+1) cycles and high for the same number of cycles.
- R4: The extreme settings give the expected extreme periods. A=0, B=0 gives 22 cycles, the shortest possible. A=3, B=63 gives 5632 cycles, the longest.
- R5: A divisor change made while en_i is high and bus_idle_i is low has no effect on the period. The new value is loaded at the first clock edge where bus_idle_i is high or en_i is low.
- R6: While en_i is low, scl_o is held high, tick_o is held low, and all counters are cleared. After en_i is sampled high at an edge, scl_o first goes low exactly 11×(A+1)×(B+1) edges later.
- R7: tick_o is a one-cycle pulse that occurs four times per period. It is high in the cycles where the phase position becomes 0 (scl_o rises, or the period starts), 6, 11 (scl_o falls) and 17. The phase position advances by one every (A+1)×(B+1) cycles.
- R8: tick_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Clock generation enable; low clears all counters |
| bus_idle_i | input | 1 | High when no transfer is in progress; allows divisor loading |
| div_a_i | input | 2 | First-stage divisor, stored as value minus one |
| div_b_i | input | 6 | Second-stage divisor, stored as value minus one |
| tick_o | output | 1 | One-cycle pulse at the four quarter points of the serial period |
| scl_o | output | 1 | Serial clock level |

## Verification
The bench measures the period, the low width and the tick count on each setting in a table. The table includes the shortest and longest settings, so a design that used the raw field instead of field+1, or that swapped the stage limits, produces a wrong period. A divisor change is made in the middle of a busy transfer, and the period must not move until an idle cycle is given. A design that loads at any time would show the new period early. Separately, the first falling edge after enable is timed: a counter that is not cleared while disabled, or a phase that starts elsewhere than high, shifts that edge. The tick train is also checked for count and spacing, which would catch a decode that fires twice or drops a quarter point.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int unsigned HALF_TICKS = 11;
  localparam int unsigned PERIOD_TICKS = 2 * HALF_TICKS;
  localparam int unsigned QUARTER_TICKS = (HALF_TICKS + 1) / 2;
endpackage

// File: rtl/sclk_div_cfg.sv
module sclk_div_cfg #(
  parameter int unsigned A_W = 2,
  parameter int unsigned B_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic [B_W-1:0] div_b_i,
  output logic [A_W-1:0] act_a_o,
  output logic [B_W-1:0] act_b_o
);
  // inputs act as the pending value; capture only at idle points
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_a_o <= '0;
      act_b_o <= '0;
    end else if (load_i) begin
      act_a_o <= div_a_i;
      act_b_o <= div_b_i;
    end
  end
endmodule

// File: rtl/sclk_div_stage.sv
module sclk_div_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] lim_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_lim;

  // >= keeps the wrap safe if the limit drops below the running count
  assign at_lim = (cnt_q >= lim_i);
  assign wrap_o = step_i && !clr_i && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (step_i)   cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sclk_div_phase.sv
module sclk_div_phase
  import sclk_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic scl_o,
  output logic tick_o
);
  localparam int unsigned PW = $clog2(PERIOD_TICKS);
  localparam logic [PW-1:0] LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] Q1   = PW'(QUARTER_TICKS);
  localparam logic [PW-1:0] Q2   = PW'(HALF_TICKS);
  localparam logic [PW-1:0] Q3   = PW'(HALF_TICKS + QUARTER_TICKS);

  logic [PW-1:0] ph_q, ph_nxt;
  logic          mark;
  logic          tick_q;

  assign ph_nxt = (ph_q == LAST) ? '0 : ph_q + 1'b1;
  assign mark   = (ph_nxt == '0) || (ph_nxt == Q1) || (ph_nxt == Q2) || (ph_nxt == Q3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      ph_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= step_i && mark;
      if (step_i) ph_q <= ph_nxt;
    end
  end

  assign scl_o  = (ph_q < Q2);
  assign tick_o = tick_q;
endmodule

// File: rtl/sclk_div_top.sv
module sclk_div_top #(
  parameter int unsigned A_W = 2,
  parameter int unsigned B_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           bus_idle_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic [B_W-1:0] div_b_i,
  output logic           tick_o,
  output logic           scl_o
);
  logic [A_W-1:0] act_a;
  logic [B_W-1:0] act_b;
  logic           clr;
  logic           wrap_a, wrap_b;

  assign clr = !en_i;

  sclk_div_cfg #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (bus_idle_i || !en_i),
    .div_a_i (div_a_i),
    .div_b_i (div_b_i),
    .act_a_o (act_a),
    .act_b_o (act_b)
  );

  sclk_div_stage #(.W(A_W)) u_stage_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (en_i),
    .lim_i  (act_a),
    .wrap_o (wrap_a)
  );

  sclk_div_stage #(.W(B_W)) u_stage_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (wrap_a),
    .lim_i  (act_b),
    .wrap_o (wrap_b)
  );

  sclk_div_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (wrap_b),
    .scl_o  (scl_o),
    .tick_o (tick_o)
  );
endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk #(
  parameter int unsigned A_W = 2,
  parameter int unsigned B_W = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           bus_idle_i,
  input logic           tick_o,
  input logic           scl_o,
  input logic [A_W-1:0] act_a_i,
  input logic [B_W-1:0] act_b_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !tick_o));

  // R5
  busy_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bus_idle_i) |=> ($stable(act_a_i) && $stable(act_b_i)));

  // R7
  edge_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(en_i) && (scl_o != $past(scl_o))) |-> tick_o);

  // R8
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

bind sclk_div_top sclk_div_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .bus_idle_i (bus_idle_i),
  .tick_o     (tick_o),
  .scl_o      (scl_o),
  .act_a_i    (act_a),
  .act_b_i    (act_b)
);

// File: tb/tb_sclk_div_top.sv
module tb_sclk_div_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 8;
  // {a[23:22], b[21:16], expected period[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 6'd0,  16'd22},   // R4 fastest
    {2'd1, 6'd0,  16'd44},
    {2'd0, 6'd1,  16'd44},
    {2'd3, 6'd0,  16'd88},
    {2'd2, 6'd4,  16'd330},
    {2'd1, 6'd9,  16'd440},
    {2'd0, 6'd63, 16'd1408},
    {2'd3, 6'd63, 16'd5632}  // R4 slowest
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       bus_idle_i = 1'b1;
  logic [1:0] div_a_i = '0;
  logic [5:0] div_b_i = '0;
  logic       tick_o, scl_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  sclk_div_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .bus_idle_i(bus_idle_i),
    .div_a_i(div_a_i), .div_b_i(div_b_i), .tick_o(tick_o), .scl_o(scl_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL R2 watchdog: cycles %0d expected < %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic lvl);
    while (scl_o != lvl) @(negedge clk_i);
  endtask

  // one full period from a falling edge to the next
  task automatic measure(output int per, output int low, output int nt, output int adj);
    int t0;
    logic prev;
    wait_level(1'b1);
    wait_level(1'b0);
    t0 = cyc;
    nt = tick_o ? 1 : 0;
    prev = tick_o;
    adj = 0;
    do begin
      @(negedge clk_i);
      if (tick_o) nt++;
      if (tick_o && prev) adj++;
      prev = tick_o;
    end while (scl_o == 1'b0);
    low = cyc - t0;
    do begin
      @(negedge clk_i);
      if (tick_o) nt++;
      if (tick_o && prev) adj++;
      prev = tick_o;
    end while (scl_o == 1'b1);
    per = cyc - t0;
    if (tick_o) nt--;
  endtask

  task automatic load_idle(input logic [1:0] a, input logic [5:0] b);
    @(negedge clk_i);
    en_i = 1'b0;
    bus_idle_i = 1'b1;
    div_a_i = a;
    div_b_i = b;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    int per, low, nt, adj, n, cnt;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 scl in reset", int'(scl_o), 1);
    check("R1 tick in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 scl after reset", int'(scl_o), 1);
    check("R6 tick while disabled", int'(tick_o), 0);

    // R2 R3 R4 R7 R8 vector table
    for (int i = 0; i < NVEC; i++) begin
      load_idle(VEC[i][23:22], VEC[i][21:16]);
      en_i = 1'b1;
      bus_idle_i = 1'b0;
      measure(per, low, nt, adj);
      check("R2 period", per, int'(VEC[i][15:0]));
      check("R3 low width", low, int'(VEC[i][15:0]) / 2);
      check("R7 ticks per period", nt, 4);
      check("R8 adjacent ticks", adj, 0);
    end

    // R6 first fall after enable, a=1 b=2 -> N=6
    load_idle(2'd1, 6'd2);
    check("R6 scl high while disabled", int'(scl_o), 1);
    en_i = 1'b1;
    bus_idle_i = 1'b0;
    n = 0;
    cnt = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (tick_o) cnt++;
    end while (scl_o == 1'b1);
    check("R6 first fall edges", n, 66);
    // ticks at phase 6 and at 11 seen before first fall inclusive
    check("R7 ticks before first fall", cnt, 2);

    // R6 disable mid-period returns scl high
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check("R6 scl after disable", int'(scl_o), 1);
    check("R6 tick after disable", int'(tick_o), 0);

    // R5 change while busy is ignored, then taken at idle
    load_idle(2'd0, 6'd1);
    en_i = 1'b1;
    bus_idle_i = 1'b0;
    repeat (10) @(negedge clk_i);
    div_a_i = 2'd3;
    div_b_i = 6'd3;
    measure(per, low, nt, adj);
    check("R5 period unchanged while busy", per, 44);
    measure(per, low, nt, adj);
    check("R5 period still unchanged", per, 44);
    @(negedge clk_i);
    bus_idle_i = 1'b1;
    @(negedge clk_i);
    bus_idle_i = 1'b0;
    measure(per, low, nt, adj);
    measure(per, low, nt, adj);
    check("R5 period after idle load", per, 352);
    check("R3 low width after idle load", low, 176);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule